// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands over a fixed number of clock cycles and returns a double-width signed product as an upper and a lower half. A single adder/subtractor of operand width, extended by one bit, operates on the upper half of a combined product register. The lower half of that register first holds the multiplier, and one extra bit below it remembers the multiplier bit examined in the previous step.

Each step looks at the current lowest multiplier bit together with the remembered bit. A run of ones is begun by a subtraction of the multiplicand and ended by an addition, and every step ends with an arithmetic right shift of the whole register. A one-cycle start pulse loads the operands. The busy output stays high while the steps run, and a one-cycle done pulse marks a valid product. The product outputs keep their value until the next accepted start.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, busy and done are 0 and both product halves read 0.
- R2: A start pulse seen while busy is 0 loads the operands, and busy is 1 from the next cycle on.
- R3: busy stays high for exactly W cycles, where W is the operand width (default 32). Then done is 1 for exactly one cycle, and busy is 0 in that cycle.
- R4: When done is 1, {prod_hi, prod_lo} equals the 2W-bit signed product of the multiplicand and multiplier that were loaded. prod_hi holds bits 2W-1..W and prod_lo holds bits W-1..0.
- R5: The product is correct when an operand is zero or -1, and when the multiplicand is the most negative value, including the most negative value times itself (2^(2W-2)).
- R6: A start pulse while busy is 1 has no effect. The running product and the timing of done are unchanged.
- R7: While busy is 0 and no start is given, prod_hi and prod_lo hold their last value.
- R8: Small cases follow the recoding rule: 2 times 7 gives 14, and 2 times -3 gives -6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a multiply |
| mcand | input | W | Signed multiplicand, sampled on an accepted start |
| mplier | input | W | Signed multiplier, sampled on an accepted start |
| busy | output | 1 | High while recoding steps run |
| done | output | 1 | One-cycle pulse when the product is valid |
| prod_hi | output | W | Upper half of the signed product |
| prod_lo | output | W | Lower half of the signed product |

## Verification
The hardest case to reach is a start request that arrives in the middle of a running multiply. It carries operands whose product differs from the one in progress. The stimulus raises start with fresh operands partway through a run. The scoreboard then has to see exactly one done at the original time, carrying the original product. The most negative multiplicand is also driven. In that case an upper half computed at only W bits would flip its sign during the arithmetic shift, so the product-wide comparison exposes it.

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  mc_q;
  logic [W-1:0]  hi_q, lo_q;
  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  logic [W:0] hi_x, mc_x, sum;
  logic       last;

  assign hi_x = {hi_q[W-1], hi_q};
  assign mc_x = {mc_q[W-1], mc_q};
  assign last = (cnt_q == CW'(W - 1));

  always_comb begin
    case ({lo_q[0], prev_q})
      2'b10:   sum = hi_x - mc_x;
      2'b01:   sum = hi_x + mc_x;
      default: sum = hi_x;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q   <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          mc_q   <= mcand;
          hi_q   <= '0;
          lo_q   <= mplier;
          prev_q <= 1'b0;
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        hi_q   <= sum[W:1];
        lo_q   <= {sum[0], lo_q[W-1:1]};
        prev_q <= lo_q[0];
        cnt_q  <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign prod_hi = hi_q;
  assign prod_lo = lo_q;
endmodule

module booth_seq_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] mcand,
  input logic [W-1:0] mplier,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo
);
  localparam int PW = 2 * W;

  logic signed [W-1:0]  a_q, b_q;
  logic signed [PW-1:0] ref_p;
  int unsigned          bc;

  assign ref_p = PW'(a_q) * PW'(b_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      bc  <= 0;
    end else if (start && !busy) begin
      a_q <= mcand;
      b_q <= mplier;
      bc  <= 0;
    end else if (busy) begin
      bc <= bc + 1;
    end
  end

  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bc == W);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> {prod_hi, prod_lo} == ref_p);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(prod_hi) && $stable(prod_lo));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
  .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
);

// File: tb/booth_seq_mul_test.sv
module booth_seq_mul_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic         busy, done;
  logic [W-1:0] prod_hi, prod_lo;

  int n_cmp = 0;
  int n_bad = 0;
  int n_done = 0;
  logic [2*W-1:0] expq[$];
  logic [W-1:0] xs = 32'h1234_5678;

  always #5 clk = ~clk;

  booth_seq_mul #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (expq.size() == 0) check("R6 unexpected done", 64'd1, 64'd0);
      else check("R4 product", {prod_hi, prod_lo}, expq.pop_front());
    end
  end

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string req,
                     input bool_intrude);
    logic signed [2*W-1:0] e;
    int n;
    e = (2*W)'($signed(a)) * (2*W)'($signed(b));
    expq.push_back(e);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", 64'(busy), 64'd1);
    n = 0;
    while (busy && n < 200) begin
      n++;
      if (bool_intrude && n == 10) begin
        start = 1'b1; mcand = ~a; mplier = b + 32'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check("R3 busy length", 64'(n), 64'(W));
    check("R3 done with busy low", {62'd0, done, busy}, 64'd2);
    check({req, " product"}, {prod_hi, prod_lo}, e);
    @(negedge clk);
    check("R3 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2*W-1:0] held;
    int d0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {prod_hi, prod_lo}, 64'd0);
    check("R1 reset flags", {62'd0, busy, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(32'd2, 32'd7, "R8 2x7", 1'b0);
    check("R8 2x7 is 14", {prod_hi, prod_lo}, 64'd14);
    run(32'd2, -32'sd3, "R8 2x-3", 1'b0);
    check("R8 2x-3 is -6", {prod_hi, prod_lo}, 64'hFFFF_FFFF_FFFF_FFFA);
    run(32'd0, 32'h8765_4321, "R5 zero", 1'b0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 -1x-1", 1'b0);
    run(32'hFFFF_FFFF, 32'd12345, "R5 -1xpos", 1'b0);
    run(32'h8000_0000, 32'h8000_0000, "R5 min x min", 1'b0);
    check("R5 min squared", {prod_hi, prod_lo}, 64'h4000_0000_0000_0000);
    run(32'h8000_0000, 32'd1, "R5 min x 1", 1'b0);
    run(32'h8000_0000, 32'hFFFF_FFFF, "R5 min x -1", 1'b0);
    run(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4 max x max", 1'b0);
    run(32'h5555_5555, 32'hAAAA_AAAA, "R4 alternating", 1'b0);

    d0 = n_done;
    run(32'd1000, 32'h8000_0001, "R6 start while busy", 1'b1);
    check("R6 single done", 64'(n_done - d0), 64'd1);

    held = {prod_hi, prod_lo};
    repeat (6) @(negedge clk);
    check("R7 hold while idle", {prod_hi, prod_lo}, held);
    check("R7 idle flags", {62'd0, busy, done}, 64'd0);

    for (int i = 0; i < 12; i++) begin
      xs = xs ^ (xs << 13); xs = xs ^ (xs >> 17); xs = xs ^ (xs << 5);
      mcand = xs;
      xs = xs ^ (xs << 13); xs = xs ^ (xs >> 17); xs = xs ^ (xs << 5);
      run(mcand, xs, "R4 mixed", 1'b0);
    end

    check("R4 all results consumed", 64'(expq.size()), 64'd0);
    finish_run();
  end
endmodule